// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous RAM Port

This block is one access port of a synchronous static RAM. Its word is 72 bits wide, cut into eight lanes of nine bits. On every rising clock edge the port samples a pair of chip selects, one active low and one active high, eight active-low lane enables, a read/write select and an address. It then either writes the enabled lanes or reads them. Lanes that are not enabled keep their contents on a write and stay silent on a read.

The port has no tri-state pins. A lane that would float is shown by a clear bit in `rvalid_lanes` and by zeros on its slice of `rdata`. Two level inputs act on the outputs at once, without waiting for the clock. `oe_n` held high silences every lane. `sleep` held high also silences every lane, whatever else is happening.

The `pipe_mode` input sets the read latency. In flow-through mode the result is shown for one cycle, starting at the edge after the read is sampled. In pipelined mode the same result is shown one cycle later. The memory is split into one array per lane, so that each lane can map onto a block RAM with its own write enable.

Top module: `bsram_port`

## Requirements
- R1: The port is selected only when `ce_lo_n` is 0 and `ce_hi` is 1. In any other cycle nothing is written, and the cycle yields no valid read lanes.
- R2: On a selected cycle with `rd_wr` = 0, lane i (bits 9*i+8 down to 9*i of the word) is written from `wdata` only when `lane_en_n[i]` is 0. All other lanes keep their stored value.
- R3: On a selected cycle with `rd_wr` = 1, the resulting `rvalid_lanes` is exactly the inverse of the sampled `lane_en_n`. Each valid lane carries the stored data. Each lane whose valid bit is clear shows zero on `rdata`.
- R4: A selected cycle with `lane_en_n` all ones writes nothing, and the read it makes has no valid lane.
- R5: While `oe_n` is 1, `rvalid_lanes` and `rdata` are all zero, without waiting for a clock edge. When `oe_n` returns to 0 inside the output window, the pending result reappears.
- R6: While `sleep` is 1, `rvalid_lanes` and `rdata` are all zero, without waiting for a clock edge.
- R7: With `pipe_mode` = 0, a read sampled at edge k is shown from edge k until edge k+1. It is gone after edge k+1 if that edge carries no read.
- R8: With `pipe_mode` = 1, a read sampled at edge k shows no valid lane between edges k and k+1. It is shown from edge k+1 until edge k+2.
- R9: A clock edge with `rst` = 1 clears all pending read results, so `rvalid_lanes` is zero afterwards. Stored memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output stages |
| ce_lo_n | input | 1 | Active-low chip select |
| ce_hi | input | 1 | Active-high chip select |
| lane_en_n | input | 8 | Active-low enable for each 9-bit lane |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Word address |
| wdata | input | 72 | Write data, eight 9-bit lanes |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep; silences all outputs |
| rdata | output | 72 | Read data, zero in lanes that are not valid |
| rvalid_lanes | output | 8 | Lanes driving read data (clear = floating) |

## Verification
Writes and reads are run with a single-lane mask, the lower four lanes, the upper four lanes, all lanes, no lanes and random masks. Each full-word read-back then shows whether a masked write leaked into neighbouring lanes or dropped an enabled one. Both wrong chip-select combinations are applied to writes and to reads, which tells a correct select decode apart from one that checks only one of the two selects. Reads are run in both latency modes, and the bench checks the cycle before and the cycle after the output window. `oe_n` and `sleep` are toggled in the middle of a cycle to show that they act without the clock.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  typedef enum logic {
    LAT_FLOW = 1'b0,
    LAT_PIPE = 1'b1
  } lat_mode_e;

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode #(
  parameter int LANES = 8
) (
  input  logic             ce_lo_n,
  input  logic             ce_hi,
  input  logic [LANES-1:0] lane_en_n,
  input  logic             rd_wr,
  output logic [LANES-1:0] wr_mask,
  output logic [LANES-1:0] rd_mask
);

  logic sel;

  always_comb begin
    sel     = (!ce_lo_n) && ce_hi;
    wr_mask = '0;
    rd_mask = '0;
    if (sel) begin
      if (rd_wr) rd_mask = ~lane_en_n;
      else       wr_mask = ~lane_en_n;
    end
  end

endmodule

// File: rtl/bsram_lane_mem.sv
module bsram_lane_mem #(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rd_q <= store[addr];
  end

endmodule

// File: rtl/bsram_out.sv
module bsram_out
  import bsram_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        rd_mask,
  input  logic [LANES*LANE_W-1:0] rd_word,
  input  logic                    pipe_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rvalid_lanes
);

  localparam int WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  s1_mask;
  logic [LANES-1:0]  s2_mask;
  logic [WORD_W-1:0] s2_data;
  logic [LANES-1:0]  pick_mask;
  logic [WORD_W-1:0] pick_data;
  logic              drive_ok;
  lat_mode_e         mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_mask <= '0;
      s2_mask <= '0;
      s2_data <= '0;
    end else begin
      s1_mask <= rd_mask;
      s2_mask <= s1_mask;
      s2_data <= rd_word;
    end
  end

  always_comb begin
    mode      = lat_mode_e'(pipe_mode);
    drive_ok  = (!oe_n) && (!sleep);
    pick_mask = (mode == LAT_PIPE) ? s2_mask : s1_mask;
    pick_data = (mode == LAT_PIPE) ? s2_data : rd_word;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    assign rvalid_lanes[g] = pick_mask[g] & drive_ok;
    assign rdata[g*LANE_W +: LANE_W] =
      (pick_mask[g] & drive_ok) ? pick_data[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/bsram_port.sv
module bsram_port #(
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce_lo_n,
  input  logic                    ce_hi,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    rd_wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    pipe_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rvalid_lanes
);

  localparam int WORD_W = LANES * LANE_W;

  logic [LANES-1:0]  wr_mask;
  logic [LANES-1:0]  rd_mask;
  logic [WORD_W-1:0] rd_word;

  bsram_decode #(.LANES(LANES)) u_decode (
    .ce_lo_n   (ce_lo_n),
    .ce_hi     (ce_hi),
    .lane_en_n (lane_en_n),
    .rd_wr     (rd_wr),
    .wr_mask   (wr_mask),
    .rd_mask   (rd_mask)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bsram_lane_mem #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_mem (
      .clk  (clk),
      .we   (wr_mask[g]),
      .re   (rd_mask[g]),
      .addr (addr),
      .wd   (wdata[g*LANE_W +: LANE_W]),
      .rd_q (rd_word[g*LANE_W +: LANE_W])
    );
  end

  bsram_out #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .rd_mask      (rd_mask),
    .rd_word      (rd_word),
    .pipe_mode    (pipe_mode),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .rdata        (rdata),
    .rvalid_lanes (rvalid_lanes)
  );

endmodule

// File: rtl/bsram_port_chk.sv
module bsram_port_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce_lo_n,
  input logic                    ce_hi,
  input logic [LANES-1:0]        lane_en_n,
  input logic                    rd_wr,
  input logic                    pipe_mode,
  input logic                    oe_n,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        rvalid_lanes
);

  logic sel_now;
  assign sel_now = (!ce_lo_n) && ce_hi;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && !sel_now) |=> (pipe_mode || rvalid_lanes == '0)); // R1

  AST_READ_LANES_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && sel_now && rd_wr) |=>
      (pipe_mode || (rvalid_lanes & $past(lane_en_n)) == '0)); // R3

  AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rvalid_lanes == '0) |-> (rdata == '0)); // R3

  AST_NO_LANE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && sel_now && lane_en_n == '1) |=>
      (pipe_mode || rvalid_lanes == '0)); // R4

  AST_OE_SILENCES: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (rvalid_lanes == '0)); // R5

  AST_SLEEP_SILENCES: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (rvalid_lanes == '0 && rdata == '0)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (rvalid_lanes == '0)); // R9

endmodule

bind bsram_port bsram_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ce_lo_n      (ce_lo_n),
  .ce_hi        (ce_hi),
  .lane_en_n    (lane_en_n),
  .rd_wr        (rd_wr),
  .pipe_mode    (pipe_mode),
  .oe_n         (oe_n),
  .sleep        (sleep),
  .rdata        (rdata),
  .rvalid_lanes (rvalid_lanes)
);

// File: tb/bsram_port_bench.sv
module bsram_port_bench;

  localparam int CLK_P  = 10;
  localparam int LANES  = 8;
  localparam int LANE_W = 9;
  localparam int ADDR_W = 6;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              ce_lo_n, ce_hi, rd_wr, pipe_mode, oe_n, sleep;
  logic [LANES-1:0]  lane_en_n;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wdata;
  logic [WORD_W-1:0] rdata;
  logic [LANES-1:0]  rvalid_lanes;

  logic [WORD_W-1:0] model [DEPTH];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bsram_port #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_bsram_port (
    .clk (clk), .rst (rst), .ce_lo_n (ce_lo_n), .ce_hi (ce_hi),
    .lane_en_n (lane_en_n), .rd_wr (rd_wr), .addr (addr), .wdata (wdata),
    .pipe_mode (pipe_mode), .oe_n (oe_n), .sleep (sleep),
    .rdata (rdata), .rvalid_lanes (rvalid_lanes)
  );

  task automatic check(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    ce_lo_n = 1'b1; ce_hi = 1'b0; rd_wr = 1'b1; lane_en_n = '1;
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [WORD_W-1:0] d,
                          logic [LANES-1:0] en_n, logic c0 = 1'b0, logic c1 = 1'b1);
    @(negedge clk);
    ce_lo_n = c0; ce_hi = c1; rd_wr = 1'b0; addr = a; wdata = d; lane_en_n = en_n;
    @(posedge clk);
    if (!c0 && c1)
      for (int i = 0; i < LANES; i++)
        if (!en_n[i]) model[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
    @(negedge clk);
    go_idle();
  endtask

  function automatic logic [WORD_W-1:0] exp_word(logic [ADDR_W-1:0] a, logic [LANES-1:0] m);
    logic [WORD_W-1:0] r = '0;
    for (int i = 0; i < LANES; i++)
      if (m[i]) r[i*LANE_W +: LANE_W] = model[a][i*LANE_W +: LANE_W];
    return r;
  endfunction

  // Read, then check the output window for the current latency mode.
  task automatic read_chk(logic [ADDR_W-1:0] a, logic [LANES-1:0] en_n, string req,
                          logic c0 = 1'b0, logic c1 = 1'b1);
    logic [LANES-1:0] m;
    m = (!c0 && c1) ? ~en_n : '0;
    @(negedge clk);
    ce_lo_n = c0; ce_hi = c1; rd_wr = 1'b1; addr = a; lane_en_n = en_n;
    @(posedge clk);
    @(negedge clk);
    go_idle();
    #1;
    if (pipe_mode) begin
      check(rvalid_lanes == '0, "R8 early", {64'd0, rvalid_lanes}, '0);
      @(posedge clk);
      @(negedge clk);
      #1;
    end
    check(rvalid_lanes == m, req, {64'd0, rvalid_lanes}, {64'd0, m});
    check(rdata == exp_word(a, m), req, rdata, exp_word(a, m));
  endtask

  task automatic t_reset();
    rst = 1'b1; go_idle(); oe_n = 1'b0; sleep = 1'b0; pipe_mode = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    check(rvalid_lanes == '0 && rdata == '0, "R9 reset", rdata, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++)
      do_write(a[ADDR_W-1:0], {8{a[8:0] + 9'h101}} ^ {LANES{9'h0a5}}, '0);
    for (int a = 0; a < 4; a++) read_chk(a[ADDR_W-1:0], '0, "R2 fill");
  endtask

  task automatic t_lane_patterns();
    logic [LANES-1:0] pats [4];
    pats[0] = 8'b1111_0111; pats[1] = 8'b1111_0000;
    pats[2] = 8'b0000_1111; pats[3] = 8'b0000_0000;
    for (int p = 0; p < 4; p++) begin
      do_write(6'd10 + p[5:0], {WORD_W{1'b1}} ^ {8{p[8:0]}}, pats[p]);
      read_chk(6'd10 + p[5:0], '0, "R2 masked write");
      read_chk(6'd10 + p[5:0], pats[p], "R3 masked read");
    end
  endtask

  task automatic t_deselect();
    do_write(6'd20, {WORD_W{1'b0}}, '0, 1'b1, 1'b1);
    do_write(6'd20, {WORD_W{1'b0}}, '0, 1'b0, 1'b0);
    read_chk(6'd20, '0, "R1 read deselect ce_lo_n", 1'b1, 1'b1);
    read_chk(6'd20, '0, "R1 read deselect ce_hi", 1'b0, 1'b0);
    read_chk(6'd20, '0, "R1 contents kept");
  endtask

  task automatic t_no_lanes();
    do_write(6'd21, {WORD_W{1'b0}}, '1);
    read_chk(6'd21, '1, "R4 no lane read");
    read_chk(6'd21, '0, "R4 no lane write");
  endtask

  task automatic t_async(bit use_sleep);
    logic [WORD_W-1:0] e;
    string req;
    req = use_sleep ? "R6 sleep" : "R5 oe";
    e = exp_word(6'd11, '1);
    @(negedge clk);
    ce_lo_n = 1'b0; ce_hi = 1'b1; rd_wr = 1'b1; addr = 6'd11; lane_en_n = '0;
    @(posedge clk);
    @(negedge clk);
    go_idle();
    #1;
    if (use_sleep) sleep = 1'b1; else oe_n = 1'b1;
    #1;
    check(rvalid_lanes == '0 && rdata == '0, req, rdata, '0);
    if (use_sleep) sleep = 1'b0; else oe_n = 1'b0;
    #1;
    check(rvalid_lanes == '1 && rdata == e, req, rdata, e);
  endtask

  task automatic t_flow_window();
    read_chk(6'd12, '0, "R7 flow window");
    @(posedge clk);
    @(negedge clk);
    #1;
    check(rvalid_lanes == '0, "R7 window closes", {64'd0, rvalid_lanes}, '0);
  endtask

  task automatic t_pipe();
    pipe_mode = 1'b1;
    read_chk(6'd13, '0, "R8 pipe full");
    read_chk(6'd11, 8'b1010_0101, "R8 pipe masked");
    @(posedge clk);
    @(negedge clk);
    #1;
    check(rvalid_lanes == '0, "R8 window closes", {64'd0, rvalid_lanes}, '0);
    @(negedge clk);
    ce_lo_n = 1'b0; ce_hi = 1'b1; rd_wr = 1'b1; addr = 6'd13; lane_en_n = '0;
    @(posedge clk);
    @(negedge clk);
    go_idle(); rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; #1;
    check(rvalid_lanes == '0, "R9 reset drops pending", {64'd0, rvalid_lanes}, '0);
    read_chk(6'd13, '0, "R9 contents survive reset");
    pipe_mode = 1'b0;
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) begin
      logic [ADDR_W-1:0] a;
      logic [LANES-1:0] m;
      a = ADDR_W'($urandom_range(0, DEPTH - 1));
      m = LANES'($urandom);
      do_write(a, {$urandom, $urandom, $urandom}, m);
      pipe_mode = k[0];
      read_chk(a, LANES'($urandom), "R3 random mask");
      read_chk(a, '0, "R2 random write");
    end
    pipe_mode = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fill();
    t_lane_patterns();
    t_deselect();
    t_no_lanes();
    t_async(1'b0);
    t_async(1'b1);
    t_flow_window();
    t_pipe();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule